// File: doc/BRIEF.md
# Halt and Wake-Up Sequencer

This block stops the processor core when the core executes a halt command and later decides how the core comes back. While halted, the core clock enable is low, so memory, registers and port levels stay as they are. The block watches four wake sources: an external reset request, a pending interrupt, a falling edge on an input port pin whose build-time wake mask bit is set, and a watchdog overflow.

Each wake ends in one of four one-cycle pulses. `full_rst` asks for a complete device initialization. `warm_rst` asks for a restart that clears only the program counter and stack pointer. `resume_next` lets the core carry on with the instruction after the halt. `isr_vector` sends the core into the interrupt service routine. An interrupt wake vectors only when the interrupt is enabled and the stack has room. Otherwise it resumes like a port wake. Before vectoring, the block holds the core stopped for a dummy period whose length is a parameter.

When several sources arrive in the same cycle, the external reset wins, then the watchdog, then the interrupt, then the port. Port pins pass through a two-stage synchronizer, and each pin is then compared with its previous synchronized value to find falling edges.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After `rst_n` is released, `core_run` is 1 and `full_rst`, `warm_rst`, `resume_next` and `isr_vector` are all 0.
- R2: While running, `halt_cmd` high at a clock edge (with no external reset request) makes `core_run` 0 from the next cycle. A halted core stays halted with no outcome pulse until a wake source appears.
- R3: `ext_rst_req` high at a clock edge, in any state, gives a one-cycle `full_rst` pulse in the next cycle with `core_run` 1. It takes priority over every other source and over `halt_cmd`.
- R4: `wdt_ovf` high at a clock edge while halted, with no external reset request, gives a `warm_rst` pulse and `core_run` 1 in the next cycle. This holds even if an interrupt or port edge arrives in the same cycle.
- R5: `irq_pend` high while halted, with `irq_en` 1 and `stack_full` 0 and no higher source, holds `core_run` at 0 for DUMMY_CYCLES further cycles. `isr_vector` then pulses in the same cycle that `core_run` returns to 1. With DUMMY_CYCLES = 2, this happens on the third edge after the interrupt is first sampled.
- R6: `irq_pend` high while halted with `irq_en` 0 or `stack_full` 1, and no higher source, gives `resume_next` and `core_run` 1 in the next cycle.
- R7: A 1-to-0 change on port bit i, where bit i of WAKE_MASK is 1, wakes a halted core with `resume_next`. The pulse and `core_run` 1 appear on the third clock edge after the change: two synchronizer stages, then the compare.
- R8: A falling edge on a pin whose WAKE_MASK bit is 0, and a rising edge on any pin, leave a halted core halted with no outcome pulse.
- R9: At most one of the four outcome pulses is high in any cycle. `core_run` only rises together with an outcome pulse.
- R10: While running, `wdt_ovf`, `irq_pend` and port edges produce no outcome pulse and leave `core_run` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| halt_cmd | input | 1 | Core is executing a halt command |
| ext_rst_req | input | 1 | External reset request, synchronous to clk |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| irq_pend | input | 1 | Some interrupt request is pending |
| irq_en | input | 1 | Interrupt servicing is enabled |
| stack_full | input | 1 | Return stack has no free entry |
| port_in | input | PORT_W | Asynchronous port pins watched for falling edges |
| core_run | output | 1 | Core clock enable, low while halted or in the dummy period |
| full_rst | output | 1 | One-cycle request for full initialization |
| warm_rst | output | 1 | One-cycle request to clear program counter and stack pointer |
| resume_next | output | 1 | One-cycle request to continue after the halt |
| isr_vector | output | 1 | One-cycle request to enter the interrupt service routine |

## Verification
The bound checker checks on every cycle the rules that need only one cycle of history. These are the single-pulse rule, halt entry, the source priority for the external reset and the watchdog, the choice between resuming and vectoring on an interrupt wake, the absence of outcomes while running, and that a vector only ever follows the dummy period. Some behaviour depends on a stream of stimulus over many cycles, and only the bench scenarios can show it. This covers the exact dummy-period length, the three-edge latency of a port wake through the synchronizer, masked pins and rising edges that never wake, and the order of outcomes across a sequence of halts.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_DUMMY = 2'd2
  } hwc_state_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_EXT  = 3'd1,
    SRC_WDT  = 3'd2,
    SRC_IRQ  = 3'd3,
    SRC_PORT = 3'd4
  } hwc_src_e;

  typedef enum logic [2:0] {
    OUT_NONE   = 3'd0,
    OUT_FULL   = 3'd1,
    OUT_WARM   = 3'd2,
    OUT_RESUME = 3'd3,
    OUT_VECTOR = 3'd4
  } hwc_out_e;

  // Fixed priority: external reset, watchdog, interrupt, port edge.
  function automatic hwc_src_e pick_source(input logic ext, input logic wdt,
                                           input logic irq, input logic port);
    if (ext)       return SRC_EXT;
    else if (wdt)  return SRC_WDT;
    else if (irq)  return SRC_IRQ;
    else if (port) return SRC_PORT;
    else           return SRC_NONE;
  endfunction

  // An interrupt is serviced only if enabled and a stack entry is free.
  function automatic logic irq_serviceable(input logic en, input logic full);
    return en && !full;
  endfunction

  function automatic hwc_out_e source_outcome(input hwc_src_e src, input logic en,
                                              input logic full);
    case (src)
      SRC_EXT:  return OUT_FULL;
      SRC_WDT:  return OUT_WARM;
      SRC_IRQ:  return irq_serviceable(en, full) ? OUT_VECTOR : OUT_RESUME;
      SRC_PORT: return OUT_RESUME;
      default:  return OUT_NONE;
    endcase
  endfunction

  // Falling edge on each bit, restricted to the wake-enabled pins.
  function automatic logic masked_fall(input logic [63:0] prev, input logic [63:0] cur,
                                       input logic [63:0] mask);
    return |(prev & ~cur & mask);
  endfunction

endpackage

// File: rtl/hwc_port_edge.sv
module hwc_port_edge #(
  parameter int              PORT_W    = 8,
  parameter logic [PORT_W-1:0] WAKE_MASK = '1,
  parameter int              SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins,
  output logic [PORT_W-1:0] fall_vec,
  output logic              wake
);
  import hwc_pkg::*;

  localparam int PAD_W = 64 - PORT_W;

  logic [PORT_W-1:0] stage [SYNC_STAGES];
  logic [PORT_W-1:0] prev_q;
  logic [PORT_W-1:0] synced;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= '1;
          else        stage[g] <= pins;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= '1;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign synced = stage[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= synced;
  end

  assign fall_vec = prev_q & ~synced;
  assign wake = masked_fall({{PAD_W{1'b0}}, prev_q}, {{PAD_W{1'b0}}, synced},
                            {{PAD_W{1'b0}}, WAKE_MASK});

endmodule

// File: rtl/hwc_arbiter.sv
module hwc_arbiter (
  input  logic              ext,
  input  logic              wdt,
  input  logic              irq,
  input  logic              port,
  input  logic              irq_en,
  input  logic              stack_full,
  output hwc_pkg::hwc_src_e src,
  output hwc_pkg::hwc_out_e outcome
);
  import hwc_pkg::*;

  always_comb begin
    src     = pick_source(ext, wdt, irq, port);
    outcome = source_outcome(src, irq_en, stack_full);
  end

endmodule

// File: rtl/hwc_seq.sv
module hwc_seq #(
  parameter int DUMMY_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_cmd,
  input  logic              ext_rst_req,
  input  hwc_pkg::hwc_out_e outcome,
  output logic              core_run,
  output logic              halted,
  output logic              dummy_active,
  output logic              full_rst,
  output logic              warm_rst,
  output logic              resume_next,
  output logic              isr_vector
);
  import hwc_pkg::*;

  localparam int DUM = (DUMMY_CYCLES < 1) ? 1 : DUMMY_CYCLES;
  localparam int CW  = (DUM > 1) ? $clog2(DUM) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(DUM - 1);

  hwc_state_e      state_q;
  logic [CW-1:0]   cnt_q;
  logic            cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      cnt_q       <= '0;
      full_rst    <= 1'b0;
      warm_rst    <= 1'b0;
      resume_next <= 1'b0;
      isr_vector  <= 1'b0;
    end else begin
      full_rst    <= 1'b0;
      warm_rst    <= 1'b0;
      resume_next <= 1'b0;
      isr_vector  <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (ext_rst_req)   full_rst <= 1'b1;
          else if (halt_cmd) state_q  <= ST_HALT;
        end
        ST_HALT: begin
          case (outcome)
            OUT_FULL: begin
              full_rst <= 1'b1;
              state_q  <= ST_RUN;
            end
            OUT_WARM: begin
              warm_rst <= 1'b1;
              state_q  <= ST_RUN;
            end
            OUT_RESUME: begin
              resume_next <= 1'b1;
              state_q     <= ST_RUN;
            end
            OUT_VECTOR: begin
              cnt_q   <= CNT_LOAD;
              state_q <= ST_DUMMY;
            end
            default: state_q <= ST_HALT;
          endcase
        end
        ST_DUMMY: begin
          if (ext_rst_req) begin
            full_rst <= 1'b1;
            state_q  <= ST_RUN;
          end else if (cnt_done) begin
            isr_vector <= 1'b1;
            state_q    <= ST_RUN;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign core_run     = (state_q == ST_RUN);
  assign halted       = (state_q == ST_HALT);
  assign dummy_active = (state_q == ST_DUMMY);

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int                PORT_W       = 8,
  parameter logic [PORT_W-1:0] WAKE_MASK    = '1,
  parameter int                DUMMY_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt_cmd,
  input  logic              ext_rst_req,
  input  logic              wdt_ovf,
  input  logic              irq_pend,
  input  logic              irq_en,
  input  logic              stack_full,
  input  logic [PORT_W-1:0] port_in,
  output logic              core_run,
  output logic              full_rst,
  output logic              warm_rst,
  output logic              resume_next,
  output logic              isr_vector
);
  import hwc_pkg::*;

  logic [PORT_W-1:0] port_fall;
  logic              port_wake;
  logic              halted;
  logic              dummy_active;
  hwc_src_e          wake_src;
  hwc_out_e          wake_outcome;

  hwc_port_edge #(
    .PORT_W      (PORT_W),
    .WAKE_MASK   (WAKE_MASK),
    .SYNC_STAGES (2)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins     (port_in),
    .fall_vec (port_fall),
    .wake     (port_wake)
  );

  hwc_arbiter u_arb (
    .ext        (ext_rst_req),
    .wdt        (wdt_ovf),
    .irq        (irq_pend),
    .port       (port_wake),
    .irq_en     (irq_en),
    .stack_full (stack_full),
    .src        (wake_src),
    .outcome    (wake_outcome)
  );

  hwc_seq #(
    .DUMMY_CYCLES (DUMMY_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_cmd     (halt_cmd),
    .ext_rst_req  (ext_rst_req),
    .outcome      (wake_outcome),
    .core_run     (core_run),
    .halted       (halted),
    .dummy_active (dummy_active),
    .full_rst     (full_rst),
    .warm_rst     (warm_rst),
    .resume_next  (resume_next),
    .isr_vector   (isr_vector)
  );

endmodule

// File: rtl/hwc_checker.sv
module hwc_checker (
  input logic clk,
  input logic rst_n,
  input logic halt_cmd,
  input logic ext_rst_req,
  input logic wdt_ovf,
  input logic irq_pend,
  input logic irq_en,
  input logic stack_full,
  input logic port_wake,
  input logic halted,
  input logic dummy_active,
  input logic core_run,
  input logic full_rst,
  input logic warm_rst,
  input logic resume_next,
  input logic isr_vector
);
  logic any_out;
  assign any_out = full_rst | warm_rst | resume_next | isr_vector;

  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full_rst, warm_rst, resume_next, isr_vector}));

  a_r9_run_needs_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> any_out);

  a_r2_halt_entry: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && halt_cmd && !ext_rst_req |=> halted && !core_run);

  a_r2_stay_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !ext_rst_req && !wdt_ovf && !irq_pend && !port_wake |=> halted && !any_out);

  a_r3_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_req |=> full_rst && core_run);

  a_r4_wdt_warm: assert property (@(posedge clk) disable iff (!rst_n)
    halted && wdt_ovf && !ext_rst_req |=> warm_rst && core_run);

  a_r5_enter_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    halted && irq_pend && irq_en && !stack_full && !ext_rst_req && !wdt_ovf
    |=> dummy_active && !core_run);

  a_r5_vector_after_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    isr_vector |-> $past(dummy_active));

  a_r6_irq_continue: assert property (@(posedge clk) disable iff (!rst_n)
    halted && irq_pend && !(irq_en && !stack_full) && !ext_rst_req && !wdt_ovf
    |=> resume_next);

  a_r7_port_resume: assert property (@(posedge clk) disable iff (!rst_n)
    halted && port_wake && !ext_rst_req && !wdt_ovf && !irq_pend |=> resume_next);

  a_r10_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    core_run && !ext_rst_req |=> !any_out);

endmodule

bind halt_wake_ctrl hwc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_cmd     (halt_cmd),
  .ext_rst_req  (ext_rst_req),
  .wdt_ovf      (wdt_ovf),
  .irq_pend     (irq_pend),
  .irq_en       (irq_en),
  .stack_full   (stack_full),
  .port_wake    (port_wake),
  .halted       (halted),
  .dummy_active (dummy_active),
  .core_run     (core_run),
  .full_rst     (full_rst),
  .warm_rst     (warm_rst),
  .resume_next  (resume_next),
  .isr_vector   (isr_vector)
);

// File: tb/test_halt_wake_ctrl.sv
module test_halt_wake_ctrl;
  localparam int         W    = 8;
  localparam logic [7:0] MASK = 8'h0F;
  localparam int         DUM  = 2;

  localparam int C_NONE = 0, C_FULL = 1, C_WARM = 2, C_RES = 3, C_VEC = 4, C_MULTI = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_cmd = 1'b0, ext_rst_req = 1'b0, wdt_ovf = 1'b0;
  logic irq_pend = 1'b0, irq_en = 1'b0, stack_full = 1'b0;
  logic [W-1:0] port_in = '1;
  logic core_run, full_rst, warm_rst, resume_next, isr_vector;

  halt_wake_ctrl #(.PORT_W(W), .WAKE_MASK(MASK), .DUMMY_CYCLES(DUM)) i_halt_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd), .ext_rst_req(ext_rst_req),
    .wdt_ovf(wdt_ovf), .irq_pend(irq_pend), .irq_en(irq_en), .stack_full(stack_full),
    .port_in(port_in), .core_run(core_run), .full_rst(full_rst), .warm_rst(warm_rst),
    .resume_next(resume_next), .isr_vector(isr_vector)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    mon_on = 1'b0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int out_code();
    int n = int'(full_rst) + int'(warm_rst) + int'(resume_next) + int'(isr_vector);
    if (n > 1)       return C_MULTI;
    if (full_rst)    return C_FULL;
    if (warm_rst)    return C_WARM;
    if (resume_next) return C_RES;
    if (isr_vector)  return C_VEC;
    return C_NONE;
  endfunction

  // Driver side: expected outcome items.
  task automatic expect_out(input int code, input string req);
    exp_q.push_back(code);
    tag_q.push_back(req);
  endtask

  // Monitor side: every observed outcome is popped and compared.
  always @(negedge clk) begin
    if (mon_on) begin
      int c;
      c = out_code();
      if (c != C_NONE) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10", "unexpected outcome pulse", c, C_NONE);
        end else begin
          int    e;
          string r;
          e = exp_q.pop_front();
          r = tag_q.pop_front();
          check(c == e, r, "outcome code (R9 single pulse)", c, e);
          check(core_run == 1'b1, r, "core_run with outcome", int'(core_run), 1);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_halt();
    halt_cmd = 1'b1;
    tick(1);
    halt_cmd = 1'b0;
    check(core_run == 1'b0, "R2", "core_run after halt", int'(core_run), 0);
  endtask

  task automatic wait_run(input string req, input int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (core_run) break;
      tick(1);
    end
    check(core_run == 1'b1, req, "core_run after wake", int'(core_run), 1);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check(core_run == 1'b1, "R1", "core_run after reset", int'(core_run), 1);
    check(out_code() == C_NONE, "R1", "outcomes after reset", out_code(), C_NONE);
    tick(3);
    mon_on = 1'b1;

    // R2 halt holds without a source, then R4 watchdog wake
    enter_halt();
    tick(6);
    check(core_run == 1'b0, "R2", "still halted with no source", int'(core_run), 0);
    expect_out(C_WARM, "R4");
    wdt_ovf = 1'b1;
    tick(1);
    wdt_ovf = 1'b0;
    check(core_run == 1'b1, "R4", "run one cycle after watchdog", int'(core_run), 1);
    tick(2);

    // R5 vectored interrupt with dummy period of DUM cycles
    enter_halt();
    expect_out(C_VEC, "R5");
    irq_en = 1'b1; stack_full = 1'b0; irq_pend = 1'b1;
    tick(1);
    check(core_run == 1'b0, "R5", "dummy cycle 1 core stopped", int'(core_run), 0);
    tick(1);
    check(core_run == 1'b0, "R5", "dummy cycle 2 core stopped", int'(core_run), 0);
    tick(1);
    check(core_run == 1'b1, "R5", "run after dummy period", int'(core_run), 1);
    irq_pend = 1'b0;
    tick(2);

    // R6 interrupt disabled, then stack full
    enter_halt();
    expect_out(C_RES, "R6");
    irq_en = 1'b0; irq_pend = 1'b1;
    tick(1);
    irq_pend = 1'b0;
    check(core_run == 1'b1, "R6", "disabled irq resumes next cycle", int'(core_run), 1);
    tick(2);
    enter_halt();
    expect_out(C_RES, "R6");
    irq_en = 1'b1; stack_full = 1'b1; irq_pend = 1'b1;
    tick(1);
    irq_pend = 1'b0; stack_full = 1'b0;
    check(core_run == 1'b1, "R6", "stack full irq resumes", int'(core_run), 1);
    tick(2);

    // R7 unmasked pin falls: wake on third edge
    enter_halt();
    expect_out(C_RES, "R7");
    port_in = 8'hFD;
    tick(2);
    check(core_run == 1'b0, "R7", "still halted during sync", int'(core_run), 0);
    tick(1);
    check(core_run == 1'b1, "R7", "run on third edge", int'(core_run), 1);
    port_in = 8'hFF;
    tick(5);

    // R8 masked pin falls and rising edges do not wake; then R3 ext wakes
    enter_halt();
    port_in = 8'hBF;
    tick(6);
    check(core_run == 1'b0, "R8", "masked fall ignored", int'(core_run), 0);
    port_in = 8'hFF;
    tick(6);
    check(core_run == 1'b0, "R8", "rising edge ignored", int'(core_run), 0);
    expect_out(C_FULL, "R3");
    ext_rst_req = 1'b1;
    tick(1);
    ext_rst_req = 1'b0;
    check(core_run == 1'b1, "R3", "run after external reset", int'(core_run), 1);
    tick(2);

    // R4 priority: watchdog beats interrupt and port edge
    enter_halt();
    expect_out(C_WARM, "R4");
    wdt_ovf = 1'b1; irq_en = 1'b1; irq_pend = 1'b1; port_in = 8'hFE;
    tick(1);
    wdt_ovf = 1'b0; irq_pend = 1'b0; port_in = 8'hFF;
    check(core_run == 1'b1, "R4", "watchdog wins", int'(core_run), 1);
    tick(5);

    // R3 priority: external reset beats watchdog and interrupt
    enter_halt();
    expect_out(C_FULL, "R3");
    ext_rst_req = 1'b1; wdt_ovf = 1'b1; irq_pend = 1'b1;
    tick(1);
    ext_rst_req = 1'b0; wdt_ovf = 1'b0; irq_pend = 1'b0;
    check(core_run == 1'b1, "R3", "ext reset wins", int'(core_run), 1);
    tick(2);

    // R10 sources while running have no effect
    wdt_ovf = 1'b1;
    tick(1);
    wdt_ovf = 1'b0; irq_pend = 1'b1;
    tick(2);
    irq_pend = 1'b0; port_in = 8'hF0;
    tick(5);
    port_in = 8'hFF;
    tick(5);
    check(core_run == 1'b1, "R10", "core keeps running", int'(core_run), 1);

    // R3 external reset while running
    expect_out(C_FULL, "R3");
    ext_rst_req = 1'b1; halt_cmd = 1'b1;
    tick(1);
    ext_rst_req = 1'b0; halt_cmd = 1'b0;
    check(core_run == 1'b1, "R3", "ext reset beats halt_cmd", int'(core_run), 1);
    tick(3);

    check(exp_q.size() == 0, "R9", "expected outcomes left unseen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule